// File: doc/BRIEF.md
# Register-Programmed SPI Master with Frame Control

This block is an SPI bus master that sits on a simple word-addressed register port. Software loads the configuration while the engine is off: frame width, clock phase and polarity, bit order, slave-select behaviour between frames, and transfer direction. Software then turns the engine on, writes words into a transmit queue and collects received words from a receive queue. The engine forms frames on `sclk`, `mosi` and an active-low select `ss_n`, and it samples `miso`.

Each direction has a 32-entry queue. A status word reports the queue levels. A set of raw and masked event bits drives the `irq` output. Transmit-and-receive and transmit-only transfers run for as long as the transmit queue holds words. Receive-only transfers run for a fixed number of frames, set by a frame-count register. The register port has no back-pressure: every write or read strobe completes in the cycle it is given. A write to a full transmit queue and a read from an empty receive queue are therefore reported through sticky event bits and are not stalled.

Top module: `spi_frame_master`

Register word addresses on `reg_addr`: 0 control, 1 frame count, 2 enable, 3 select gate, 4 baud divider, 5 TX threshold, 6 RX threshold, 7 status, 8 raw events, 9 event mask, 10 masked events, 11 clear-on-read, 12 TX data (write), 13 RX data (read).

## Requirements
- R1: Control bits [1:0] set the frame width: 0 gives 4 bits, 1 gives 8 bits, 2 gives 16 bits, and the reserved code 3 acts as 8 bits. The received word is right-aligned with zeros above the frame.
- R2: Control bit 7 sets the idle `sclk` level (0 low, 1 high). With control bit 6 at 0, data is sampled on the leading edge of each bit. With bit 6 at 1, the first edge starts the first bit and data is sampled on the trailing edge.
- R3: Control bit 12 set to 0 sends and receives the most significant bit first; set to 1 it sends and receives the least significant bit first.
- R4: Control bits [9:8] set the select behaviour after each frame. Code 0 keeps `ss_n` low while words remain to be sent. Code 1 raises it for half an `sclk` period before the next frame, and code 2 raises it for a whole period. The reserved code 3 acts as 0.
- R5: Control bit 10 sets the time from `ss_n` falling to the start of the first data bit: 0 gives half an `sclk` period and 1 gives a whole period.
- R6: Control bits [19:18] select the transfer mode. Code 0 (and the reserved code 3) transmits and receives. Code 1 transmits only and stores nothing in the RX queue. Code 2 receives only and drives `mosi` low. A receive-only run clocks exactly (frame count + 1) frames and then stops.
- R7: One `sclk` period lasts as many clock cycles as the baud divider value, which should be even. Values below 2 act as 2. The reset value is 2.
- R8: Writing 0 to the enable register halts the engine, raises `ss_n` and empties both queues. TX data writes are dropped while the engine is off. Writes to the control, frame-count and baud registers are ignored while the engine is on.
- R9: Status bits are: bit 0 busy, bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full.
- R10: Event bits are: bit 0 TX level at or below its threshold, bit 1 TX overflow, bit 2 RX underflow, bit 3 RX overflow, bit 4 RX level above its threshold. A TX write to a full queue is dropped and sets bit 1. An RX read of an empty queue returns 0 and sets bit 2. Bits 1 to 3 stay set until the clear register is read. `irq` is high when any raw event bit ANDed with the mask is set.
- R11: Bit 0 of the select-gate register gates `ss_n`. When it is 0, `ss_n` stays high while frames still run.
- R12: The threshold events compare the current queue level with the threshold registers. Both thresholds reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Masked event request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |

## Verification
A table of frames is sent in transmit-receive mode with `miso` tied back to `mosi`. The table covers all four phase and polarity combinations, all frame widths including the reserved code, and both bit orders. A wrong width shows up as a mismatch in the returned word. A wrong bit order appears only in the captured `mosi` bit stream, and a wrong phase shows up as a wrong captured bit or a wrong count of sampling edges. Pairs of back-to-back words under each select mode measure the inter-frame gap and the lead time in cycles, which separates the half-period settings from the full-period settings. Receive-only runs with `miso` held high, and transmit-only runs, separate the frame-count limit and the RX store rule from the queue-driven behaviour. A flood of TX writes at a slow baud rate exposes overflow, the threshold events, masking and clear-on-read.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int SPIM_FW = 16;

  // register word addresses
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_NFRM = 4'd1;
  localparam logic [3:0] A_ENA  = 4'd2;
  localparam logic [3:0] A_SSEL = 4'd3;
  localparam logic [3:0] A_BAUD = 4'd4;
  localparam logic [3:0] A_TXTH = 4'd5;
  localparam logic [3:0] A_RXTH = 4'd6;
  localparam logic [3:0] A_STAT = 4'd7;
  localparam logic [3:0] A_RAW  = 4'd8;
  localparam logic [3:0] A_MASK = 4'd9;
  localparam logic [3:0] A_MSKD = 4'd10;
  localparam logic [3:0] A_CLR  = 4'd11;
  localparam logic [3:0] A_TXD  = 4'd12;
  localparam logic [3:0] A_RXD  = 4'd13;

  localparam logic [1:0] MODE_TO = 2'd1;
  localparam logic [1:0] MODE_RO = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} eng_st_t;

  function automatic logic [5:0] frame_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd4;
      2'd2:    return 6'd16;
      default: return 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: level never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R10: the writer gates its pushes on full
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && !flush |-> !push);
  // R10: the reader gates its pops on empty
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !flush |-> !pop);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DIVW = 16,
  parameter int CNTW = 16,
  localparam int LW  = CNTW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [1:0]         dfs,
  input  logic               cpha,
  input  logic               cpol,
  input  logic [1:0]         csm,
  input  logic               lead_full,
  input  logic               lsb_first,
  input  logic [1:0]         tmod,
  input  logic [DIVW-1:0]    baud,
  input  logic [CNTW-1:0]    nfrm,
  input  logic               tx_avail,
  input  logic [SPIM_FW-1:0] tx_word,
  output logic               tx_pop,
  input  logic               rx_room,
  output logic               rx_push,
  output logic               rx_ovf,
  output logic [SPIM_FW-1:0] rx_word,
  output logic               busy,
  output logic               ss_act,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  eng_st_t             st;
  logic [DIVW-1:0]     hcnt, half_raw, hlf;
  logic [5:0]          hidx, bits, hlast;
  logic                waitq, tick, ro, to_only, csm_gap, have_work;
  logic                frame_end, do_load;
  logic [SPIM_FW-1:0]  sh, rxs, tx_src, mask16;
  logic [LW-1:0]       left;

  assign half_raw  = baud >> 1;
  assign hlf       = (half_raw == '0) ? DIVW'(1) : half_raw;
  assign tick      = (hcnt == hlf - 1'b1);
  assign bits      = frame_bits(dfs);
  assign hlast     = (bits << 1) - 1'b1;
  assign ro        = (tmod == MODE_RO);
  assign to_only   = (tmod == MODE_TO);
  assign csm_gap   = (csm == 2'd1) || (csm == 2'd2);
  assign have_work = ro ? (left != '0) : tx_avail;
  assign frame_end = (st == ST_SHIFT) && tick && (hidx == hlast);
  assign do_load   = run && have_work &&
                     ((st == ST_IDLE) || (frame_end && !csm_gap) ||
                      (st == ST_GAP && tick && !waitq));
  assign tx_pop    = do_load && !ro;
  assign rx_push   = frame_end && !to_only && rx_room;
  assign rx_ovf    = frame_end && !to_only && !rx_room;
  assign tx_src    = ro ? '0 : tx_word;
  assign mask16    = 16'((32'd1 << bits) - 32'd1);
  assign rx_word   = lsb_first ? (rxs >> (6'd16 - bits)) : (rxs & mask16);
  assign busy      = (st != ST_IDLE);
  assign sclk      = (st == ST_SHIFT) ? (cpol ^ cpha ^ hidx[0]) : cpol;
  assign mosi      = lsb_first ? sh[0] : sh[SPIM_FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; hcnt <= '0; hidx <= '0; waitq <= 1'b0;
      sh <= '0; rxs <= '0; ss_act <= 1'b0; left <= '0;
    end else if (!run) begin
      st <= ST_IDLE; hcnt <= '0; ss_act <= 1'b0;
      left <= {1'b0, nfrm} + LW'(1);
    end else begin
      if (do_load) begin
        sh <= lsb_first ? tx_src : (tx_src << (6'd16 - bits));
        if (ro) left <= left - 1'b1;
      end
      case (st)
        ST_IDLE: if (do_load) begin
          st <= ST_LEAD; ss_act <= 1'b1; waitq <= lead_full; hcnt <= '0;
        end
        ST_LEAD: if (tick) begin
          hcnt <= '0;
          if (waitq) waitq <= 1'b0;
          else begin st <= ST_SHIFT; hidx <= '0; end
        end else hcnt <= hcnt + 1'b1;
        ST_SHIFT: if (tick) begin
          hcnt <= '0;
          if (!hidx[0]) begin
            rxs  <= lsb_first ? {miso, rxs[SPIM_FW-1:1]} : {rxs[SPIM_FW-2:0], miso};
            hidx <= hidx + 1'b1;
          end else if (hidx == hlast) begin
            hidx <= '0;
            if (csm_gap) begin
              st <= ST_GAP; ss_act <= 1'b0; waitq <= (csm == 2'd2);
            end else if (!do_load) begin
              st <= ST_IDLE; ss_act <= 1'b0;
            end
          end else begin
            sh   <= lsb_first ? (sh >> 1) : (sh << 1);
            hidx <= hidx + 1'b1;
          end
        end else hcnt <= hcnt + 1'b1;
        ST_GAP: if (tick) begin
          hcnt <= '0;
          if (waitq) waitq <= 1'b0;
          else if (do_load) begin
            st <= ST_LEAD; ss_act <= 1'b1; waitq <= lead_full;
          end else st <= ST_IDLE;
        end else hcnt <= hcnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: select stays asserted for every bit of a frame
  a_r4_ss_held_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SHIFT |-> ss_act);
  // R6: an exhausted receive-only run never restarts while enabled
  a_r6_ro_stops: assert property (@(posedge clk) disable iff (!rst_n)
    run && ro && left == '0 && st == ST_IDLE |=> st == ST_IDLE);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spim_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DIVW  = 16,
  parameter int CNTW  = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic        ss_n,
  input  logic        miso
);
  logic [31:0]         ctrl_q;
  logic [CNTW-1:0]     nfrm_q;
  logic [DIVW-1:0]     baud_q;
  logic [CW-1:0]       txth_q, rxth_q, tx_cnt, rx_cnt;
  logic [4:0]          mask_q, raw;
  logic                en_q, ssel_q, txo_q, rxo_q, rxu_q;
  logic                tx_wr, tx_push, tx_full, tx_empty, tx_pop;
  logic                rx_rd, rx_pop, rx_full, rx_empty, rx_push, rx_ovf;
  logic                clr_rd, cfg_ok, eng_busy, ss_act;
  logic [SPIM_FW-1:0]  tx_word, rx_in, rx_out;

  assign cfg_ok  = reg_wr && !en_q;
  assign tx_wr   = reg_wr && (reg_addr == A_TXD);
  assign tx_push = tx_wr && en_q && !tx_full;
  assign rx_rd   = reg_rd && (reg_addr == A_RXD);
  assign rx_pop  = rx_rd && !rx_empty;
  assign clr_rd  = reg_rd && (reg_addr == A_CLR);
  assign raw     = {(rx_cnt > rxth_q), rxo_q, rxu_q, txo_q, (tx_cnt <= txth_q)};
  assign irq     = |(raw & mask_q);
  assign ss_n    = !(ssel_q && ss_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; nfrm_q <= '0; baud_q <= DIVW'(2); en_q <= 1'b0; ssel_q <= 1'b0;
      txth_q <= '0; rxth_q <= '0; mask_q <= '0;
      txo_q <= 1'b0; rxo_q <= 1'b0; rxu_q <= 1'b0;
    end else begin
      if (cfg_ok && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (cfg_ok && reg_addr == A_NFRM) nfrm_q <= reg_wdata[CNTW-1:0];
      if (cfg_ok && reg_addr == A_BAUD) baud_q <= reg_wdata[DIVW-1:0];
      if (reg_wr && reg_addr == A_ENA)  en_q   <= reg_wdata[0];
      if (reg_wr && reg_addr == A_SSEL) ssel_q <= reg_wdata[0];
      if (reg_wr && reg_addr == A_TXTH) txth_q <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == A_RXTH) rxth_q <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[4:0];
      txo_q <= (txo_q && !clr_rd) || (tx_wr && en_q && tx_full);
      rxu_q <= (rxu_q && !clr_rd) || (rx_rd && rx_empty);
      rxo_q <= (rxo_q && !clr_rd) || rx_ovf;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_NFRM:  reg_rdata = 32'(nfrm_q);
      A_ENA:   reg_rdata = 32'(en_q);
      A_SSEL:  reg_rdata = 32'(ssel_q);
      A_BAUD:  reg_rdata = 32'(baud_q);
      A_TXTH:  reg_rdata = 32'(txth_q);
      A_RXTH:  reg_rdata = 32'(rxth_q);
      A_STAT:  reg_rdata = 32'({rx_full, rx_empty, tx_empty, tx_full, eng_busy});
      A_RAW,
      A_CLR:   reg_rdata = 32'(raw);
      A_MASK:  reg_rdata = 32'(mask_q);
      A_MSKD:  reg_rdata = 32'(raw & mask_q);
      A_RXD:   reg_rdata = rx_empty ? 32'd0 : 32'(rx_out);
      default: reg_rdata = 32'd0;
    endcase
  end

  spim_fifo #(.W(SPIM_FW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q), .push(tx_push), .din(reg_wdata[SPIM_FW-1:0]),
    .pop(tx_pop), .dout(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(SPIM_FW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q), .push(rx_push), .din(rx_in),
    .pop(rx_pop), .dout(rx_out), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_engine #(.DIVW(DIVW), .CNTW(CNTW)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(en_q),
    .dfs(ctrl_q[1:0]), .cpha(ctrl_q[6]), .cpol(ctrl_q[7]), .csm(ctrl_q[9:8]),
    .lead_full(ctrl_q[10]), .lsb_first(ctrl_q[12]), .tmod(ctrl_q[19:18]),
    .baud(baud_q), .nfrm(nfrm_q),
    .tx_avail(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
    .rx_room(!rx_full), .rx_push(rx_push), .rx_ovf(rx_ovf), .rx_word(rx_in),
    .busy(eng_busy), .ss_act(ss_act), .sclk(sclk), .mosi(mosi), .miso(miso));

  // R8: one cycle after the engine is off it is idle with select high
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (ss_n && !eng_busy));
  // R10: overflow stays latched until the clear register is read
  a_r10_txo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    txo_q && !clr_rd |=> txo_q);
endmodule

// File: tb/spi_frame_master_tb_top.sv
`timescale 1ns/1ps
module spi_frame_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sclk, mosi, ss_n, miso;
  logic        miso_mode = 1'b0, miso_const = 1'b0;
  logic        cpol_cur = 1'b0, cpha_cur = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign miso = miso_mode ? miso_const : mosi;

  spi_frame_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .ss_n(ss_n), .miso(miso));

  // bus monitor, evaluated away from the active edge
  logic [15:0] cap;
  int ncap, lead_cnt, last_gap, ss_hi, ss_rise, hi_len, last_hi, clr_req, clr_seen;
  logic prev_sclk, prev_ss, seen_edge, ss_low_seen;
  initial begin
    cap = '0; ncap = 0; lead_cnt = 0; last_gap = 0; ss_hi = 0; ss_rise = 0;
    hi_len = 0; last_hi = 0; clr_req = 0; clr_seen = 0;
    prev_sclk = 1'b0; prev_ss = 1'b1; seen_edge = 1'b0; ss_low_seen = 1'b0;
  end
  always @(negedge clk) begin
    logic edge_now;
    if (clr_req != clr_seen) begin
      cap = '0; ncap = 0; ss_rise = 0; hi_len = 0; last_hi = 0; ss_low_seen = 1'b0;
      clr_seen = clr_req;
    end
    edge_now = (sclk !== prev_sclk);
    if (edge_now && ((prev_sclk == cpol_cur) != cpha_cur)) begin
      cap = {cap[14:0], mosi}; ncap++;
    end
    if (sclk != cpol_cur) hi_len++;
    else if (hi_len != 0) begin last_hi = hi_len; hi_len = 0; end
    if (prev_ss && !ss_n) begin lead_cnt = 1; seen_edge = 1'b0; end
    else if (!ss_n && !seen_edge && !edge_now) lead_cnt++;
    if (edge_now) seen_edge = 1'b1;
    if (ss_n) ss_hi++;
    else begin if (prev_ss) last_gap = ss_hi; ss_hi = 0; ss_low_seen = 1'b1; end
    if (!prev_ss && ss_n) ss_rise++;
    prev_sclk = sclk; prev_ss = ss_n;
  end

  task automatic mon_clear();
    clr_req++;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      rd(4'd7, s);
      if (!s[0]) break;
    end
  endtask

  task automatic setup(input logic [31:0] ctrl, input logic [31:0] baud, input logic ssel);
    wr(4'd2, 0);
    cpol_cur = ctrl[7]; cpha_cur = ctrl[6];
    wr(4'd0, ctrl); wr(4'd4, baud); wr(4'd6, 0); wr(4'd3, {31'd0, ssel});
    mon_clear();
    wr(4'd2, 1);
  endtask

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd2) ? 16 : 8;
  endfunction

  function automatic logic [15:0] rev_bits(input logic [15:0] x, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction

  // {control word, TX word}
  localparam logic [47:0] VEC [9] = '{
    {32'h0000_0001, 16'h00A5}, {32'h0000_0041, 16'h003C}, {32'h0000_0081, 16'h00C3},
    {32'h0000_00C1, 16'h0096}, {32'h0000_1001, 16'h0017}, {32'h0000_0000, 16'h000B},
    {32'h0000_0002, 16'hBEEF}, {32'h0000_10C2, 16'h1234}, {32'h0000_0003, 16'h005A}};

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R2 reset sclk", 32'(sclk), 0);
    chk("R8 reset ss_n", 32'(ss_n), 1);
    rd(4'd7, v); chk("R9 reset status", v, 32'h0C);
    rd(4'd8, v); chk("R12 reset raw events", v, 32'h01);
    rd(4'd4, v); chk("R7 reset baud", v, 2);
    chk("R10 reset irq", 32'(irq), 0);

    // vector table: loopback frames
    for (int k = 0; k < 9; k++) begin
      logic [31:0] c;
      logic [15:0] t, m;
      int n;
      c = VEC[k][47:16]; t = VEC[k][15:0];
      n = nbits(c[1:0]);
      m = 16'((32'd1 << n) - 1);
      setup(c, 4, 1'b1);
      wr(4'd12, {16'd0, t});
      wait_idle();
      rd(4'd8, v); chk("R12 rx above threshold", {31'd0, v[4]}, 1);
      rd(4'd13, v); chk("R1 R2 loopback word", v, {16'd0, t & m});
      chk("R3 mosi bit order", {16'd0, cap & m},
          {16'd0, c[12] ? rev_bits(t & m, n) : (t & m)});
      chk("R1 sampling edges", ncap, n);
      chk("R2 idle sclk", 32'(sclk), 32'(c[7]));
    end

    // R7: sclk period from baud divider
    setup(32'h1, 6, 1'b1); wr(4'd12, 32'h55); wait_idle();
    chk("R7 half period baud 6", last_hi, 3);
    setup(32'h1, 10, 1'b1); wr(4'd12, 32'h55); wait_idle();
    chk("R7 half period baud 10", last_hi, 5);

    // R4/R5: gap and lead timing, half period = 2 cycles
    setup(32'h541, 4, 1'b1); wr(4'd12, 32'h11); wr(4'd12, 32'h22); wait_idle();
    chk("R4 gap half period", last_gap, 2);
    chk("R5 lead full period", lead_cnt, 4);
    setup(32'h241, 4, 1'b1); wr(4'd12, 32'h33); wr(4'd12, 32'h44); wait_idle();
    chk("R4 gap full period", last_gap, 4);
    chk("R5 lead half period", lead_cnt, 2);
    setup(32'h041, 4, 1'b1); wr(4'd12, 32'h66); wr(4'd12, 32'h77); wait_idle();
    chk("R4 select kept low", ss_rise, 1);
    chk("R4 two frames clocked", ncap, 16);

    // R11: select gate off
    setup(32'h1, 4, 1'b0); wr(4'd12, 32'h9C); wait_idle();
    chk("R11 ss_n held high", 32'(ss_low_seen), 0);
    rd(4'd13, v); chk("R11 frame still runs", v, 32'h9C);

    // R6: transmit only
    setup(32'h4_0001, 4, 1'b1); wr(4'd12, 32'hA1); wait_idle();
    rd(4'd7, v); chk("R6 tx-only stores nothing", {31'd0, v[3]}, 1);

    // R6: receive only, three frames
    wr(4'd2, 0); wr(4'd1, 2); miso_mode = 1'b1; miso_const = 1'b1;
    setup(32'h8_0001, 4, 1'b1); wait_idle();
    chk("R6 rx-only frame count", ncap, 24);
    chk("R6 rx-only mosi low", 32'(cap), 0);
    for (int k = 0; k < 3; k++) begin
      rd(4'd13, v); chk("R6 rx-only word", v, 32'hFF);
    end
    rd(4'd13, v); chk("R10 underflow reads zero", v, 0);
    rd(4'd8, v); chk("R10 underflow flag", {31'd0, v[2]}, 1);
    rd(4'd11, v);
    rd(4'd8, v); chk("R10 underflow cleared", {31'd0, v[2]}, 0);
    miso_mode = 1'b0;

    // R10/R12/R8: overflow at slow baud
    wr(4'd2, 0); wr(4'd5, 4); wr(4'd9, 32'h2);
    setup(32'h1, 200, 1'b1);
    for (int k = 0; k < 40; k++) wr(4'd12, k);
    rd(4'd8, v); chk("R10 tx overflow flag", {31'd0, v[1]}, 1);
    chk("R12 tx above threshold", {31'd0, v[0]}, 0);
    rd(4'd7, v); chk("R9 tx full", {31'd0, v[1]}, 1);
    chk("R10 irq raised", 32'(irq), 1);
    rd(4'd10, v); chk("R10 masked events", v, 32'h2);
    rd(4'd11, v); @(negedge clk); #1;
    chk("R10 irq cleared", 32'(irq), 0);
    wr(4'd0, 32'h2);
    rd(4'd0, v); chk("R8 config locked while on", v, 32'h1);
    wr(4'd2, 0); @(negedge clk); #1;
    rd(4'd7, v); chk("R8 disable flushes", v, 32'h0C);
    chk("R8 disable raises ss_n", 32'(ss_n), 1);
    wr(4'd12, 32'h5); rd(4'd7, v); chk("R8 write while off dropped", {31'd0, v[2]}, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule